// File: doc/BRIEF.md
# DAC Serial Register Port

This block is the slave serial port of a single-channel 16-bit DAC controller. A host sends 24-bit frames over three wires: an active-low frame select, a serial clock and a data input. Each frame holds a direction flag, a 3-bit register address and a 20-bit data field. The port keeps four registers: the DAC code, a control word, a clear code and a software control word. The current DAC code is always present on parallel outputs. Those outputs give the code as is, and also split into a 63-line thermometer for the upper six bits and a 10-bit binary part for the ladder.

Reading a register takes two frames. The first frame carries a read command. During the next frame, whatever command that frame carries, the port shifts the selected register's full 24-bit word out on the serial data output. The usual command for this second frame is the no-operation address.

The port runs from a system clock. It samples the three serial wires through two-flop synchronizers, so the system clock must run at least four times faster than the serial clock. The new DAC code is announced by a one-cycle `dac_upd_o` pulse that acts as a valid strobe. There is no ready signal: the serial host cannot be stalled. A consumer of the code must accept it in the cycle of the pulse, or read the held `dac_code_o` later.

Top module: `dac_serial_port`

## Requirements
- R1: A frame opens when `sync_n_i` falls. Data is shifted in MSB first, one bit on each falling edge of `sclk_i` while the frame is open. The frame acts only when `sync_n_i` rises after exactly 24 falling edges. Bit 23 is the direction flag (1 = read, 0 = write), bits 22..20 are the address and bits 19..0 are the data.
- R2: A valid write stores the data field into a register chosen by its address: 001 = DAC code, 010 = control, 011 = clear code, 100 = software control. The software control value appears on `swctrl_o`.
- R3: The DAC code takes data bits 19..4, and data bits 3..0 are ignored. `dac_code_o` changes only on a valid write to address 001. `dac_upd_o` pulses high for exactly one system clock cycle on each such write.
- R4: After reset, `dac_code_o` equals parameter `ZERO_CODE` (default 16'h8000, the 0 V code for symmetric references). The control, clear code and software control registers reset to zero, and `sdo_o` is low.
- R5: After a valid read of address 001, 010 or 011, the next frame shifts out {1, address, register data} MSB first. For the DAC register, the register data is {code, 4'b0000}. Bit 23 is on `sdo_o` from the opening of the frame. Each later bit appears after a rising edge of `sclk_i` and is meant to be sampled on the following falling edge.
- R6: Writes to addresses 101..111 change no register. A read of address 000, 100 or 101..111, and any valid write frame, make the next frame shift out all zeros.
- R7: A frame with a count other than 24 changes no register and leaves the pending readback word as it was.
- R8: Bit i of `dac_seg_o` is high exactly when `dac_code_o[15:10]` is greater than i. `dac_lsb_o` equals `dac_code_o[9:0]`.
- R9: `sdo_o` is low whenever no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| sync_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial readback data out |
| dac_code_o | output | 16 | Held DAC code |
| dac_upd_o | output | 1 | One-cycle strobe: new DAC code valid |
| dac_seg_o | output | 63 | Thermometer of code bits 15..10 |
| dac_lsb_o | output | 10 | Code bits 9..0 for the binary ladder |
| swctrl_o | output | 20 | Software control register |

## Verification
The bench uses the default parameters: a 24-bit frame, a 3-bit address, a 16-bit code and a reset code of 16'h8000. With these values, the full thermometer range is visible: a code of 16'hFFFF lights all 63 lines and a code of 0 lights none. The 8-system-clock serial bit period keeps the four-to-one clock ratio with margin. This lets the bench cover 23- and 25-bit frames and read-then-write chains, and compare the frame result against a behavioural model on every clock.

// File: rtl/dac_port_pkg.sv
package dac_port_pkg;
  parameter int FRAME_W = 24;
  parameter int ADDR_W  = 3;
  parameter int DATA_W  = FRAME_W - 1 - ADDR_W;
  parameter int CODE_W  = 16;

  typedef enum logic [ADDR_W-1:0] {
    ADR_NOP  = 3'd0,
    ADR_CODE = 3'd1,
    ADR_CTRL = 3'd2,
    ADR_CLR  = 3'd3,
    ADR_SW   = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
  parameter int   STAGES = 2,
  parameter logic RST    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {STAGES{RST}};
    else        q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/dps_shifter.sv
module dps_shifter
  import dac_port_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               sync_n_s,
  input  logic               sdi_s,
  input  logic [FRAME_W-1:0] load_word,
  output logic               frame_ok,
  output logic [FRAME_W-1:0] frame_word,
  output logic               sdo
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic               sclk_d, sync_d, active_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] rx_q, tx_q;
  logic               start, stop, s_rise, s_fall;

  assign start  = sync_d & ~sync_n_s;
  assign stop   = ~sync_d & sync_n_s;
  assign s_rise = ~sclk_d & sclk_s;
  assign s_fall = sclk_d & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b1;
      sync_d   <= 1'b1;
      active_q <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
    end else begin
      sclk_d <= sclk_s;
      sync_d <= sync_n_s;
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        tx_q     <= load_word;
      end else if (stop) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (s_fall) begin
          rx_q <= {rx_q[FRAME_W-2:0], sdi_s};
          if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
        end
        if (s_rise && cnt_q != '0) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign frame_ok   = stop & active_q & (cnt_q == CNT_W'(FRAME_W));
  assign frame_word = rx_q;
  assign sdo        = active_q & tx_q[FRAME_W-1];

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX)); // R7
  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0) && active_q); // R1
  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !start && !stop && !s_rise |=> $stable(tx_q)); // R5
endmodule

// File: rtl/dps_regs.sv
module dps_regs
  import dac_port_pkg::*;
#(
  parameter logic [CODE_W-1:0] ZERO_CODE = 16'h8000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_ok,
  input  logic [FRAME_W-1:0] frame_word,
  output logic [CODE_W-1:0]  code_o,
  output logic               upd_o,
  output logic [DATA_W-1:0]  sw_o,
  output logic [FRAME_W-1:0] rb_o
);
  localparam int PAD_W = DATA_W - CODE_W;

  frame_t            f;
  reg_addr_e         a;
  logic [CODE_W-1:0] code_q;
  logic [DATA_W-1:0] ctrl_q, clr_q, sw_q;
  logic [FRAME_W-1:0] rb_q, rb_next;
  logic              upd_q;

  assign f = frame_t'(frame_word);
  assign a = reg_addr_e'(f.addr);

  always_comb begin
    rb_next = '0;
    if (f.rd) begin
      case (a)
        ADR_CODE: rb_next = {1'b1, f.addr, code_q, {PAD_W{1'b0}}};
        ADR_CTRL: rb_next = {1'b1, f.addr, ctrl_q};
        ADR_CLR:  rb_next = {1'b1, f.addr, clr_q};
        default:  rb_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= ZERO_CODE;
      ctrl_q <= '0;
      clr_q  <= '0;
      sw_q   <= '0;
      rb_q   <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (frame_ok) begin
        rb_q <= rb_next;
        if (!f.rd) begin
          case (a)
            ADR_CODE: begin
              code_q <= f.data[DATA_W-1:PAD_W];
              upd_q  <= 1'b1;
            end
            ADR_CTRL: ctrl_q <= f.data;
            ADR_CLR:  clr_q  <= f.data;
            ADR_SW:   sw_q   <= f.data;
            default: ;
          endcase
        end
      end
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
  assign sw_o   = sw_q;
  assign rb_o   = rb_q;

  AST_UNDEF_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && !f.rd && f.addr > 3'd4 |=> $stable(code_q) && $stable(ctrl_q) && $stable(clr_q) && $stable(sw_q)); // R6
  AST_CODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && !f.rd && f.addr == 3'd1) |=> $stable(code_q)); // R3
  AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok && f.rd && f.addr >= 3'd4 |=> rb_q == '0); // R6
  AST_NO_FRAME_KEEPS_RB: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> $stable(rb_q)); // R7
endmodule

// File: rtl/dps_segdec.sv
module dps_segdec #(
  parameter int CODE_W   = 16,
  parameter int SEG_BITS = 6,
  localparam int SEG_N   = (1 << SEG_BITS) - 1,
  localparam int LSB_W   = CODE_W - SEG_BITS
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [SEG_N-1:0]  seg_o,
  output logic [LSB_W-1:0]  lsb_o
);
  logic [SEG_BITS-1:0] top;
  assign top = code_i[CODE_W-1:LSB_W];

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg_o[i] = (top > SEG_BITS'(i));
  end

  assign lsb_o = code_i[LSB_W-1:0];
endmodule

// File: rtl/dac_serial_port.sv
module dac_serial_port
  import dac_port_pkg::*;
#(
  parameter logic [15:0] ZERO_CODE = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_i,
  input  logic        sync_n_i,
  input  logic        sdi_i,
  output logic        sdo_o,
  output logic [15:0] dac_code_o,
  output logic        dac_upd_o,
  output logic [62:0] dac_seg_o,
  output logic [9:0]  dac_lsb_o,
  output logic [19:0] swctrl_o
);
  logic sclk_s, sync_n_s, sdi_s, frame_ok;
  logic [FRAME_W-1:0] frame_word, rb_word;

  dps_sync #(.STAGES(2), .RST(1'b1)) u_sync_sclk (.clk(clk), .rst_n(rst_n), .d_i(sclk_i),   .q_o(sclk_s));
  dps_sync #(.STAGES(2), .RST(1'b1)) u_sync_fs   (.clk(clk), .rst_n(rst_n), .d_i(sync_n_i), .q_o(sync_n_s));
  dps_sync #(.STAGES(2), .RST(1'b0)) u_sync_sdi  (.clk(clk), .rst_n(rst_n), .d_i(sdi_i),    .q_o(sdi_s));

  dps_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .sync_n_s(sync_n_s), .sdi_s(sdi_s),
    .load_word(rb_word), .frame_ok(frame_ok), .frame_word(frame_word), .sdo(sdo_o)
  );

  dps_regs #(.ZERO_CODE(ZERO_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_word(frame_word),
    .code_o(dac_code_o), .upd_o(dac_upd_o), .sw_o(swctrl_o), .rb_o(rb_word)
  );

  dps_segdec #(.CODE_W(CODE_W), .SEG_BITS(6)) u_seg (
    .code_i(dac_code_o), .seg_o(dac_seg_o), .lsb_o(dac_lsb_o)
  );

  AST_SEG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dac_seg_o) == int'(dac_code_o[15:10])); // R8
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd_o |=> !dac_upd_o); // R3
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n_s && $past(sync_n_s) |-> !sdo_o); // R9
endmodule

// File: tb/dac_serial_port_tb.sv
module dac_serial_port_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdi = 1'b0;
  logic sdo_o, dac_upd_o;
  logic [15:0] dac_code_o;
  logic [62:0] dac_seg_o;
  logic [9:0]  dac_lsb_o;
  logic [19:0] swctrl_o;

  int tests = 0, fails = 0;
  bit settle = 1'b0, done = 1'b0;
  logic [15:0] exp_code = 16'h8000;
  logic [19:0] exp_ctrl = '0, exp_clr = '0, exp_sw = '0;
  logic [23:0] exp_pend = '0;
  int exp_upd = 0, seen_upd = 0;

  always #10 clk = ~clk;

  dac_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdi_i(sdi),
    .sdo_o(sdo_o), .dac_code_o(dac_code_o), .dac_upd_o(dac_upd_o),
    .dac_seg_o(dac_seg_o), .dac_lsb_o(dac_lsb_o), .swctrl_o(swctrl_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n && dac_upd_o) seen_upd++;

  // per-clock comparison against the model while no frame result is in flight
  always @(negedge clk) begin
    if (rst_n && settle && !done) begin
      check(dac_code_o == exp_code, "R2/R3 code", 64'(dac_code_o), 64'(exp_code));
      check($countones(dac_seg_o) == int'(exp_code[15:10]) &&
            (exp_code[15:10] == 0 || dac_seg_o[exp_code[15:10]-1]),
            "R8 seg", 64'($countones(dac_seg_o)), 64'(exp_code[15:10]));
      check(dac_lsb_o == exp_code[9:0], "R8 lsb", 64'(dac_lsb_o), 64'(exp_code[9:0]));
      check(swctrl_o == exp_sw, "R2 swctrl", 64'(swctrl_o), 64'(exp_sw));
      if (sync_n) check(sdo_o == 1'b0, "R9 sdo idle", 64'(sdo_o), 64'd0);
    end
  end

  task automatic xfer(input logic [23:0] w, input int nbits, input string tag);
    logic [23:0] got, mask, expw;
    got  = '0;
    expw = exp_pend;
    mask = (nbits >= 24) ? 24'hFFFFFF : ~(24'hFFFFFF >> nbits);
    @(negedge clk); sync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i < 24) got[23-i] = sdo_o;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
    end
    repeat (4) @(negedge clk);
    settle = 1'b0;
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
    check((got & mask) == (expw & mask), {"R5/R6 readback ", tag}, 64'(got & mask), 64'(expw & mask));
    if (nbits == 24) begin
      logic [2:0] a;
      logic [19:0] d;
      logic [23:0] np;
      a = w[22:20]; d = w[19:0]; np = '0;
      if (!w[23]) begin
        case (a)
          3'd1: begin exp_code = d[19:4]; exp_upd++; end
          3'd2: exp_ctrl = d;
          3'd3: exp_clr  = d;
          3'd4: exp_sw   = d;
          default: ;
        endcase
      end else begin
        case (a)
          3'd1: np = {1'b1, a, exp_code, 4'b0000};
          3'd2: np = {1'b1, a, exp_ctrl};
          3'd3: np = {1'b1, a, exp_clr};
          default: np = '0;
        endcase
      end
      exp_pend = np;
    end
    settle = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state
    check(dac_code_o == 16'h8000, "R4 reset code", 64'(dac_code_o), 64'h8000);
    check(swctrl_o == '0 && sdo_o == 1'b0, "R4 reset sw/sdo", 64'({swctrl_o, sdo_o}), 64'd0);
    check($countones(dac_seg_o) == 32, "R4/R8 reset seg", 64'($countones(dac_seg_o)), 64'd32);
    settle = 1'b1;

    xfer({1'b0, 3'd1, 16'h1234, 4'hF}, 24, "R3 write code low bits ignored");
    xfer({1'b1, 3'd1, 20'h0}, 24, "R5 read code");
    xfer({1'b0, 3'd0, 20'h0}, 24, "R5 nop returns code word");
    xfer({1'b0, 3'd2, 20'hABCDE}, 24, "R2 write ctrl");
    xfer({1'b0, 3'd3, 20'h13579}, 24, "R2 write clr");
    xfer({1'b1, 3'd2, 20'h0}, 24, "R5 read ctrl");
    xfer({1'b1, 3'd3, 20'h0}, 24, "R5 ctrl word then read clr");
    xfer({1'b0, 3'd4, 20'h5A5A5}, 24, "R2 clr word during sw write");
    xfer({1'b0, 3'd0, 20'h0}, 24, "R6 write frame leaves zero readback");
    xfer({1'b0, 3'd5, 20'hFFFFF}, 24, "R6 undefined write");
    xfer({1'b0, 3'd7, 20'h00001}, 24, "R6 undefined write 7");
    xfer({1'b1, 3'd2, 20'h0}, 24, "R6 read ctrl");
    xfer({1'b1, 3'd4, 20'h0}, 24, "R6 ctrl word then read sw");
    xfer({1'b0, 3'd0, 20'h0}, 24, "R6 read sw yields zeros");
    xfer({1'b1, 3'd1, 20'h0}, 24, "R7 arm code read");
    xfer({1'b0, 3'd1, 20'hFFFF0}, 23, "R7 short frame");
    xfer({1'b0, 3'd1, 20'h0000F}, 25, "R7 long frame");
    xfer({1'b0, 3'd1, 20'hFFFFF}, 24, "R1 pending kept, code to max");
    xfer({1'b0, 3'd1, 20'h00000}, 24, "R8 code to zero");
    xfer({1'b0, 3'd1, 20'h7FF80}, 24, "R8 code mid");
    xfer({1'b1, 3'd1, 20'h0}, 24, "R1 read code");
    xfer({1'b0, 3'd0, 20'h0}, 24, "R5 nop returns mid code");

    repeat (10) @(negedge clk);
    check(seen_upd == exp_upd, "R3 update pulse count", 64'(seen_upd), 64'(exp_upd));
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule